// File: doc/BRIEF.md
# SRAM Bank Power-Gating Controller

This block sits beside a banked on-chip SRAM and decides which banks carry power. Software asks for a bank to be switched off by setting its bit in one of two request words. Clearing the bit asks for the bank to be switched back on. Banks 0 to 31 belong to the low word. Banks 32 to 47 belong to bits 0 to 15 of the high word. Two matching status words report progress. A status word reads as all of its valid bits set once every bank in that group has reached the state it was asked for. Software therefore polls for 0xFFFFFFFF on the low group, or for 0x0000FFFF on the high group.

Each bank has its own four-state sequencer. The states are `BK_ON` (powered and usable) and `BK_GOING_OFF` (switch opened, waiting out the settle time). They continue with `BK_OFF` (unpowered) and `BK_GOING_ON` (switch closed, waiting out the settle time).

The transitions are as follows:
- *start-down*: `BK_ON` to `BK_GOING_OFF` when the request bit is 1.
- *land-off*: `BK_GOING_OFF` to `BK_OFF` when the settle counter reaches zero.
- *start-up*: `BK_OFF` to `BK_GOING_ON` when the request bit is 0.
- *land-on*: `BK_GOING_ON` to `BK_ON` when the counter reaches zero.

Any other combination holds the state. Each transition takes a settle time set by the parameter `SETTLE_CYCLES`. The sequencer drives a per-bank power enable. A separate access port refuses reads to any bank that is not fully on: it raises an error flag and returns zero data.

Top module: `sram_bank_pwr_ctrl`

## Requirements
- R1: After reset, both request words read 0, the low status word reads 0xFFFFFFFF, the high status word reads 0x0000FFFF, and all 48 power enables are 1.
- R2: Register codes on `cfg_addr` are: 0 = low request, 1 = high request, 2 = low status, 3 = high status. Request bit i of the low word controls bank i. Request bit j (0..15) of the high word controls bank 32+j. Written high-request bits 16..31 are dropped and read back as 0. Writes to codes 2 and 3 have no effect.
- R3: A request bit of 1 asks for the bank to be off and 0 asks for it on. Once its transition completes, an off bank has power enable 0 and an on bank has power enable 1.
- R4: Starting in the cycle after the write edge that changes a bank's request bit, that bank's status bit reads 0 until its transition completes. The status bits of other banks are unaffected.
- R5: With the write edge counted as edge 0, a status bit reads 0 after edges 0 through `SETTLE_CYCLES`. It reads 1 after edge `SETTLE_CYCLES`+1.
- R6: Writing a request value equal to a bank's current request bit starts no transition, and its status bit stays 1.
- R7: Power enable falls on the edge after a power-down request (start-down) and stays 0 through `BK_OFF`. It rises on the edge that enters `BK_GOING_ON`.
- R8: An access (`acc_en`=1) to a bank that is off, in transition, requested off, or numbered 48 or above sets `acc_err` and returns 0. An access to a bank in `BK_ON` with request 0 returns `acc_mem_data` with no error. With `acc_en`=0, `acc_err` is 0.
- R9: Status bits 16..31 of the high group always read 0.
- R10: A request that changes while a bank is in transition does not cut that transition short. The bank first completes the current transition, then starts the opposite one, and its status bit stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 req low, 1 req high, 2 status low, 3 status high) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| bank_pwr_en | output | 48 | Per-bank power switch enable |
| acc_en | input | 1 | Bank access strobe |
| acc_bank | input | 6 | Bank number of the access |
| acc_mem_data | input | 32 | Data coming back from the SRAM array |
| acc_rdata | output | 32 | Gated access data |
| acc_err | output | 1 | Access refused |

## Verification
The assertions assume that reset is held low from time zero. They also assume that register writes and accesses change only between clock edges, so each write lands on exactly one edge. A further assumption is that nothing but a write alters a request bit. The stimulus follows these assumptions. It drives every input just after a falling edge. It holds `cfg_we` for exactly one rising edge. It samples the combinational read and access paths one time step after setting the address, so each observed value belongs to a known edge count after the write.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        BK_ON        = 2'd0,
        BK_GOING_OFF = 2'd1,
        BK_OFF       = 2'd2,
        BK_GOING_ON  = 2'd3
    } bank_state_e;

    localparam logic [1:0] SEL_REQ_LO = 2'd0;
    localparam logic [1:0] SEL_REQ_HI = 2'd1;
    localparam logic [1:0] SEL_STS_LO = 2'd2;
    localparam logic [1:0] SEL_STS_HI = 2'd3;

endpackage

// File: rtl/sbp_bank_seq.sv
module sbp_bank_seq
    import sbp_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_off,
    output logic settled,
    output logic pwr_en,
    output logic usable
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_ON;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: start-down, land-off, start-up, land-on
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_ON: begin
                if (want_off) begin
                    state_d = BK_GOING_OFF;
                    cnt_d   = CNT_LOAD;
                end
            end
            BK_GOING_OFF: begin
                if (cnt_q == '0) state_d = BK_OFF;
                else             cnt_d   = cnt_q - CNT_ONE;
            end
            BK_OFF: begin
                if (!want_off) begin
                    state_d = BK_GOING_ON;
                    cnt_d   = CNT_LOAD;
                end
            end
            BK_GOING_ON: begin
                if (cnt_q == '0) state_d = BK_ON;
                else             cnt_d   = cnt_q - CNT_ONE;
            end
            default: state_d = BK_ON;
        endcase
    end

    // outputs
    always_comb begin
        settled = 1'b0;
        pwr_en  = 1'b0;
        usable  = 1'b0;
        unique case (state_q)
            BK_ON: begin
                settled = !want_off;
                pwr_en  = 1'b1;
                usable  = !want_off;
            end
            BK_GOING_OFF: begin
                settled = 1'b0;
                pwr_en  = 1'b0;
            end
            BK_OFF: begin
                settled = want_off;
                pwr_en  = 1'b0;
            end
            BK_GOING_ON: begin
                settled = 1'b0;
                pwr_en  = 1'b1;
            end
            default: begin
                settled = 1'b0;
                pwr_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sbp_req_regs.sv
module sbp_req_regs
    import sbp_pkg::*;
#(
    parameter int NUM_BANKS = 48,
    parameter int REG_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           sel,
    input  logic [REG_W-1:0]     wdata,
    input  logic [NUM_BANKS-1:0] stable,
    output logic [NUM_BANKS-1:0] tgt_off,
    output logic [REG_W-1:0]     rdata
);
    localparam int HI_BANKS = NUM_BANKS - REG_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_off <= '0;
        end else if (we) begin
            if (sel == SEL_REQ_LO) tgt_off[REG_W-1:0]         <= wdata;
            if (sel == SEL_REQ_HI) tgt_off[NUM_BANKS-1:REG_W] <= wdata[HI_BANKS-1:0];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_REQ_LO: rdata = tgt_off[REG_W-1:0];
            SEL_REQ_HI: rdata = REG_W'(tgt_off[NUM_BANKS-1:REG_W]);
            SEL_STS_LO: rdata = stable[REG_W-1:0];
            SEL_STS_HI: rdata = REG_W'(stable[NUM_BANKS-1:REG_W]);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/sbp_access_gate.sv
module sbp_access_gate #(
    parameter int NUM_BANKS = 48,
    parameter int BANK_W    = 6,
    parameter int DATA_W    = 32
) (
    input  logic                 acc_en,
    input  logic [BANK_W-1:0]    acc_bank,
    input  logic [NUM_BANKS-1:0] usable,
    input  logic [DATA_W-1:0]    mem_data,
    output logic [DATA_W-1:0]    rdata,
    output logic                 err
);
    localparam int SLOTS = 1 << BANK_W;
    localparam int PAD   = SLOTS - NUM_BANKS;

    logic [SLOTS-1:0] ready_pad;
    logic             ok;

    generate
        if (PAD > 0) begin : g_pad
            assign ready_pad = {{PAD{1'b0}}, usable};
        end else begin : g_nopad
            assign ready_pad = usable;
        end
    endgenerate

    assign ok    = acc_en && ready_pad[acc_bank];
    assign err   = acc_en && !ok;
    assign rdata = ok ? mem_data : '0;

endmodule

// File: rtl/sram_bank_pwr_ctrl.sv
module sram_bank_pwr_ctrl #(
    parameter int NUM_BANKS     = 48,
    parameter int REG_W         = 32,
    parameter int SETTLE_CYCLES = 16,
    parameter int DATA_W        = 32,
    localparam int BANK_W       = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic [NUM_BANKS-1:0] bank_pwr_en,
    input  logic                 acc_en,
    input  logic [BANK_W-1:0]    acc_bank,
    input  logic [DATA_W-1:0]    acc_mem_data,
    output logic [DATA_W-1:0]    acc_rdata,
    output logic                 acc_err
);
    logic [NUM_BANKS-1:0] tgt_off;
    logic [NUM_BANKS-1:0] bank_stable;
    logic [NUM_BANKS-1:0] bank_ready;

    sbp_req_regs #(
        .NUM_BANKS (NUM_BANKS),
        .REG_W     (REG_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_addr),
        .wdata   (cfg_wdata),
        .stable  (bank_stable),
        .tgt_off (tgt_off),
        .rdata   (cfg_rdata)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            sbp_bank_seq #(
                .SETTLE_CYCLES (SETTLE_CYCLES)
            ) u_seq (
                .clk      (clk),
                .rst_n    (rst_n),
                .want_off (tgt_off[b]),
                .settled  (bank_stable[b]),
                .pwr_en   (bank_pwr_en[b]),
                .usable   (bank_ready[b])
            );
        end
    endgenerate

    sbp_access_gate #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .DATA_W    (DATA_W)
    ) u_gate (
        .acc_en   (acc_en),
        .acc_bank (acc_bank),
        .usable   (bank_ready),
        .mem_data (acc_mem_data),
        .rdata    (acc_rdata),
        .err      (acc_err)
    );

endmodule

// File: rtl/sram_bank_pwr_ctrl_chk.sv
module sram_bank_pwr_ctrl_chk
    import sbp_pkg::*;
#(
    parameter int NUM_BANKS = 48,
    parameter int REG_W     = 32,
    parameter int BANK_W    = 6,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [1:0]           cfg_addr,
    input logic [REG_W-1:0]     cfg_rdata,
    input logic [NUM_BANKS-1:0] bank_pwr_en,
    input logic                 acc_en,
    input logic [BANK_W-1:0]    acc_bank,
    input logic [DATA_W-1:0]    acc_rdata,
    input logic                 acc_err,
    input logic [NUM_BANKS-1:0] bank_stable,
    input logic [NUM_BANKS-1:0] tgt_off
);
    localparam int HI_BANKS = NUM_BANKS - REG_W;

    // R4: a status bit may only drop in the cycle its request bit changed
    p_fall_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(bank_stable) & ~bank_stable) & ~($past(tgt_off) ^ tgt_off)) == '0));

    // R3: a settled off bank is unpowered
    p_settled_off_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_stable & tgt_off & bank_pwr_en) == '0));

    // R3: a settled on bank is powered
    p_settled_on_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_stable & ~tgt_off & ~bank_pwr_en) == '0));

    // R6: request bits change only through a write
    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> (tgt_off == $past(tgt_off)));

    // R8: a refused access returns zero data
    p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_rdata == '0));

    // R8: no error without an access
    p_no_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> !acc_err);

    // R9: upper bits of the high status word stay clear
    p_hi_status_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == SEL_STS_HI) |-> (cfg_rdata[REG_W-1:HI_BANKS] == '0));

endmodule

bind sram_bank_pwr_ctrl sram_bank_pwr_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .REG_W     (REG_W),
    .BANK_W    (BANK_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_rdata   (cfg_rdata),
    .bank_pwr_en (bank_pwr_en),
    .acc_en      (acc_en),
    .acc_bank    (acc_bank),
    .acc_rdata   (acc_rdata),
    .acc_err     (acc_err),
    .bank_stable (bank_stable),
    .tgt_off     (tgt_off)
);

// File: tb/sram_bank_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bank_pwr_ctrl_tb;

    localparam int NB     = 48;
    localparam int SETTLE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NB-1:0] bank_pwr_en;
    logic        acc_en = 1'b0;
    logic [5:0]  acc_bank = '0;
    logic [31:0] acc_mem_data = 32'hA5A5_1234;
    logic [31:0] acc_rdata;
    logic        acc_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    sram_bank_pwr_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .bank_pwr_en  (bank_pwr_en),
        .acc_en       (acc_en),
        .acc_bank     (acc_bank),
        .acc_mem_data (acc_mem_data),
        .acc_rdata    (acc_rdata),
        .acc_err      (acc_err)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  gap;
        logic [1:0]  raddr;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 32'h0000_000F, 8'd0,  2'd2, 32'hFFFF_FFF0, 4'd4},  // R4 banks 0..3 drop
        '{1'b0, 2'd0, 32'h0,         8'd16, 2'd2, 32'hFFFF_FFF0, 4'd5},  // R5 still moving
        '{1'b0, 2'd0, 32'h0,         8'd1,  2'd2, 32'hFFFF_FFFF, 4'd5},  // R5 done
        '{1'b0, 2'd0, 32'h0,         8'd0,  2'd0, 32'h0000_000F, 4'd2},  // R2 low readback
        '{1'b1, 2'd1, 32'hFFFF_8001, 8'd0,  2'd3, 32'h0000_7FFE, 4'd2},  // R2 banks 32,47
        '{1'b0, 2'd0, 32'h0,         8'd0,  2'd1, 32'h0000_8001, 4'd2},  // R2 pad dropped
        '{1'b0, 2'd0, 32'h0,         8'd17, 2'd3, 32'h0000_FFFF, 4'd9},  // R9 high done
        '{1'b1, 2'd0, 32'h0000_000F, 8'd0,  2'd2, 32'hFFFF_FFFF, 4'd6},  // R6 same value
        '{1'b1, 2'd0, 32'h0000_0005, 8'd0,  2'd2, 32'hFFFF_FFF5, 4'd4},  // R4 banks 1,3 up
        '{1'b0, 2'd0, 32'h0,         8'd17, 2'd2, 32'hFFFF_FFFF, 4'd5},  // R5 done
        '{1'b1, 2'd2, 32'h0000_0000, 8'd0,  2'd0, 32'h0000_0005, 4'd2}   // R2 status write ignored
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [31:0] expv);
        cfg_addr = a;
        #1;
        check(tag, {32'h0, cfg_rdata}, {32'h0, expv});
    endtask

    task automatic acc_check(input string tag, input logic [5:0] b, input logic e_err,
                             input logic [31:0] e_data);
        acc_bank = b;
        acc_en   = 1'b1;
        #1;
        check(tag, {31'h0, acc_err, acc_rdata}, {31'h0, e_err, e_data});
        acc_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd_check("R1 req lo", 2'd0, 32'h0);
        rd_check("R1 req hi", 2'd1, 32'h0);
        rd_check("R1 sts lo", 2'd2, 32'hFFFF_FFFF);
        rd_check("R1 sts hi", 2'd3, 32'h0000_FFFF);
        check("R1 pwr_en", {16'h0, bank_pwr_en}, {16'h0, {NB{1'b1}}});

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
            step(int'(VECS[i].gap));
            rd_check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].raddr, VECS[i].expv);
        end

        // R3 R7 settled power enables: banks 0,2,32,47 off
        check("R3 pwr_en settled", {16'h0, bank_pwr_en}, {16'h0, 48'h7FFE_FFFF_FFFA});

        // R8 access gating
        acc_check("R8 off bank", 6'd2, 1'b1, 32'h0);
        acc_check("R8 on bank", 6'd5, 1'b0, 32'hA5A5_1234);
        acc_check("R8 high off bank", 6'd47, 1'b1, 32'h0);
        acc_check("R8 out of range", 6'd50, 1'b1, 32'h0);
        acc_bank = 6'd2;
        #1;
        check("R8 idle no err", {63'h0, acc_err}, 64'h0);

        // R7 power-up: enable rises on the first edge after the write
        wr(2'd0, 32'h0000_0004);
        step(1);
        check("R7 up enable", {63'h0, bank_pwr_en[0]}, 64'h1);
        rd_check("R4 up in flight", 2'd2, 32'hFFFF_FFFE);
        acc_check("R8 mid transition", 6'd0, 1'b1, 32'h0);
        step(16);
        rd_check("R5 up done", 2'd2, 32'hFFFF_FFFF);
        acc_check("R8 back on", 6'd0, 1'b0, 32'hA5A5_1234);

        // R10 reversal mid transition
        wr(2'd0, 32'h0000_0005);
        step(1);
        check("R7 down enable", {63'h0, bank_pwr_en[0]}, 64'h0);
        step(4);
        wr(2'd0, 32'h0000_0004);
        step(11);
        check("R10 down completes", {63'h0, bank_pwr_en[0]}, 64'h0);
        rd_check("R10 status low k17", 2'd2, 32'hFFFF_FFFE);
        step(3);
        check("R10 up started", {63'h0, bank_pwr_en[0]}, 64'h1);
        step(13);
        rd_check("R10 status low k33", 2'd2, 32'hFFFF_FFFE);
        step(1);
        rd_check("R10 status low k34", 2'd2, 32'hFFFF_FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule